// File: doc/BRIEF.md
# Control and Status Register Pair

This block is a small memory-mapped register bank with a plain strobe-based bus. A bus master presents a byte address, a write strobe with write data, or a read strobe, and the block answers within the same cycle. It holds two 32-bit words. The word at 0x20 combines a 16-bit control field in bits [15:0] and a 4-bit status field in bits [31:28]. Software owns the control field. Hardware owns the status field. Bits [27:16] are reserved. The word at 0x24 is a full-width scratch or configuration value that software owns.

The control field and the full data word leave the block as output ports, so surrounding logic can use them directly. The status field is loaded from a hardware input whenever a hardware write-enable is high. Software can only see it through reads. Writes take effect on the rising clock edge. Read data is combinational from the address while the read strobe is high.

Top module: `csr_pair_regs`

## Requirements
- R1: A synchronous active-high reset brings the control field to 0x3020, the status field to 4'b1010 and the data word to 0xABCDBEEF, all at the first clock edge with reset high.
- R2: A write with the write strobe high to byte address 0x20 loads write-data bits [15:0] into the control field at the next rising edge, and `ctrl_q` shows the new value.
- R3: The status field (bits [31:28] of the word at 0x20) loads `hw_stat_d` on every edge where `hw_stat_we` is high. It holds its value otherwise. No software write ever changes it.
- R4: Bits [27:16] of the word at 0x20 always read as zero, and values written to them are discarded.
- R5: A write with the write strobe high to byte address 0x24 loads all 32 bits of write data into the data word at the next rising edge, and `word_q` shows the new value.
- R6: While `rd_en` is high, `rdata` shows in the same cycle {status, 12'b0, control} for address 0x20 and the data word for address 0x24. While `rd_en` is low, `rdata` is zero.
- R7: A read of any address other than 0x20 or 0x24 returns zero, including the misaligned addresses 0x21 to 0x23. A write to such an address changes no field.
- R8: With `wr_en` low, no software-owned field changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (8) | Byte address for reads and writes |
| rd_en | input | 1 | Read strobe; enables `rdata` |
| wr_en | input | 1 | Write strobe; writes at the rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| hw_stat_we | input | 1 | Hardware load enable for the status field |
| hw_stat_d | input | 4 | Hardware value for the status field |
| ctrl_q | output | 16 | Current control field |
| word_q | output | 32 | Current data word |

## Verification
The directed patterns each isolate one case:
- All-ones writes to 0x20 show whether reserved or status bits can leak in.
- Writes with the strobe low, and writes to 0x28 and 0x21, show whether decoding is exact or only partial.
- Status loads with software writes in the same cycle show whether software can reach the status field.
- A reset in the middle of traffic shows that every field returns to its reset value.

After these, a long stream of random addresses is run. The addresses are drawn mostly near the two mapped words. The strobes and hardware loads are random. This stream is compared every cycle against a behavioural model. It separates aliasing on neighbouring addresses from correct full-address matching.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int DATA_W   = 32;
  localparam int CTRL_W   = 16;
  localparam int STAT_W   = 4;
  localparam int STAT_LSB = DATA_W - STAT_W;
  localparam int RSVD_W   = STAT_LSB - CTRL_W;

  localparam logic [CTRL_W-1:0] CTRL_RST = 16'h3020;
  localparam logic [STAT_W-1:0] STAT_RST = 4'b1010;
  localparam logic [DATA_W-1:0] WORD_RST = 32'hABCD_BEEF;

  typedef struct packed {
    logic sel_cs;
    logic sel_wd;
  } csr_sel_t;

  // Build the image of the combined word: status on top, gap zero, control low.
  function automatic logic [DATA_W-1:0] cs_image(
    input logic [STAT_W-1:0] stat,
    input logic [CTRL_W-1:0] ctrl
  );
    return {stat, {RSVD_W{1'b0}}, ctrl};
  endfunction
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec
  import csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int unsigned CS_OFFS = 32'h20,
  parameter int unsigned WD_OFFS = 32'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output csr_sel_t          sel,
  output logic              cs_we,
  output logic              wd_we
);
  localparam logic [ADDR_W-1:0] CS_A = ADDR_W'(CS_OFFS);
  localparam logic [ADDR_W-1:0] WD_A = ADDR_W'(WD_OFFS);

  always_comb begin
    sel.sel_cs = (addr == CS_A);
    sel.sel_wd = (addr == WD_A);
  end

  assign cs_we = wr_en & sel.sel_cs;
  assign wd_we = wr_en & sel.sel_wd;

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cs_we, wd_we})); // R7
  AST_NO_STROBE_NO_WE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !(cs_we || wd_we)); // R8
endmodule

// File: rtl/csr_field_reg.sv
module csr_field_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= d;
  end

  AST_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q == RST_VAL); // R1
  AST_LOAD_WHEN_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we)) |-> q == $past(d)); // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(we)) |-> $stable(q)); // R8
endmodule

// File: rtl/csr_pair_regs.sv
module csr_pair_regs
  import csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int unsigned CS_OFFS = 32'h20,
  parameter int unsigned WD_OFFS = 32'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              hw_stat_we,
  input  logic [STAT_W-1:0] hw_stat_d,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] word_q
);
  csr_sel_t          sel;
  logic              cs_we;
  logic              wd_we;
  logic [STAT_W-1:0] stat_q;

  csr_addr_dec #(
    .ADDR_W (ADDR_W),
    .CS_OFFS(CS_OFFS),
    .WD_OFFS(WD_OFFS)
  ) u_dec (
    .clk  (clk),
    .rst  (rst),
    .addr (addr),
    .wr_en(wr_en),
    .sel  (sel),
    .cs_we(cs_we),
    .wd_we(wd_we)
  );

  // Software-owned control field: only the low bits of write data reach it.
  csr_field_reg #(.W(CTRL_W), .RST_VAL(CTRL_RST)) u_ctrl (
    .clk(clk), .rst(rst), .we(cs_we), .d(wdata[CTRL_W-1:0]), .q(ctrl_q)
  );

  // Hardware-owned status field: the bus has no path into it.
  csr_field_reg #(.W(STAT_W), .RST_VAL(STAT_RST)) u_stat (
    .clk(clk), .rst(rst), .we(hw_stat_we), .d(hw_stat_d), .q(stat_q)
  );

  csr_field_reg #(.W(DATA_W), .RST_VAL(WORD_RST)) u_word (
    .clk(clk), .rst(rst), .we(wd_we), .d(wdata), .q(word_q)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (sel.sel_cs)      rdata = cs_image(stat_q, ctrl_q);
      else if (sel.sel_wd) rdata = word_q;
    end
  end

  AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata[STAT_LSB-1:CTRL_W] == '0 || !sel.sel_cs); // R4
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rdata == '0); // R6
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(sel.sel_cs || sel.sel_wd) |-> rdata == '0); // R7
  AST_STAT_SW_BLIND: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hw_stat_we)) |-> $stable(stat_q)); // R3
endmodule

// File: tb/sim_csr_pair_regs.sv
`timescale 1ns/1ps
module sim_csr_pair_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        hw_stat_we = 1'b0;
  logic [3:0]  hw_stat_d = '0;
  logic [15:0] ctrl_q;
  logic [31:0] word_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Behavioural reference state
  int unsigned m_ctrl = 0, m_stat = 0, m_word = 0;

  always #2.5 clk = ~clk;

  csr_pair_regs u0 (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .hw_stat_we(hw_stat_we),
    .hw_stat_d(hw_stat_d), .ctrl_q(ctrl_q), .word_q(word_q)
  );

  function automatic int unsigned model_read(int unsigned a, bit r);
    if (!r) return 0;
    if (a == 32) return (m_stat << 28) | m_ctrl;
    if (a == 36) return m_word;
    return 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // One cycle: drive, check against the model, clock, update the model.
  task automatic cyc(string req, bit rs, logic [7:0] a, bit r, bit w,
                     logic [31:0] d, bit hwe, logic [3:0] hv);
    rst = rs; addr = a; rd_en = r; wr_en = w; wdata = d;
    hw_stat_we = hwe; hw_stat_d = hv;
    #1;
    if (!rs) begin
      chk({req, " rdata"}, rdata, model_read(a, r));
      chk({req, " ctrl_q"}, ctrl_q, m_ctrl);
      chk({req, " word_q"}, word_q, m_word);
    end
    @(posedge clk);
    if (rs) begin
      m_ctrl = 'h3020; m_stat = 'hA; m_word = 'hABCDBEEF;
    end else begin
      if (w && a == 32) m_ctrl = d & 'hFFFF;
      if (w && a == 36) m_word = d;
      if (hwe) m_stat = hv;
    end
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc("R1", 1, 8'h00, 0, 0, 0, 0, 0);
    cyc("R1", 1, 8'h00, 0, 0, 0, 0, 0);
    // R1 reset image visible on both reads
    cyc("R1", 0, 8'h20, 1, 0, 0, 0, 0);
    chk("R1 cs image", rdata, 32'hA000_3020);
    cyc("R1", 0, 8'h24, 1, 0, 0, 0, 0);
    chk("R1 word", rdata, 32'hABCD_BEEF);
    // R6 idle read
    cyc("R6", 0, 8'h24, 0, 0, 0, 0, 0);
    // R2 R4 all-ones to combined word
    cyc("R2", 0, 8'h20, 0, 1, 32'hFFFF_FFFF, 0, 0);
    cyc("R4", 0, 8'h20, 1, 0, 0, 0, 0);
    chk("R4 gap zero", rdata, 32'hA000_FFFF);
    // R5 data word
    cyc("R5", 0, 8'h24, 0, 1, 32'h1234_5678, 0, 0);
    cyc("R5", 0, 8'h24, 1, 0, 0, 0, 0);
    chk("R5 word", word_q, 32'h1234_5678);
    // R8 strobe low
    cyc("R8", 0, 8'h24, 0, 0, 32'hDEAD_0000, 0, 0);
    cyc("R8", 0, 8'h20, 0, 0, 32'h0000_0001, 0, 0);
    cyc("R8", 0, 8'h24, 1, 0, 0, 0, 0);
    chk("R8 word kept", rdata, 32'h1234_5678);
    // R7 unmapped and misaligned
    cyc("R7", 0, 8'h28, 0, 1, 32'h0, 0, 0);
    cyc("R7", 0, 8'h21, 0, 1, 32'h0, 0, 0);
    cyc("R7", 0, 8'h25, 1, 0, 0, 0, 0);
    chk("R7 read", rdata, 32'h0);
    cyc("R7", 0, 8'h20, 1, 0, 0, 0, 0);
    chk("R7 ctrl kept", ctrl_q, 16'hFFFF);
    // R3 status load with simultaneous software write, then hold
    cyc("R3", 0, 8'h20, 0, 1, 32'hF000_0000, 1, 4'h5);
    cyc("R3", 0, 8'h20, 1, 0, 0, 0, 4'hC);
    chk("R3 loaded", rdata, 32'h5000_0000);
    cyc("R3", 0, 8'h20, 0, 1, 32'hFFFF_1111, 0, 4'h3);
    cyc("R3", 0, 8'h20, 1, 0, 0, 0, 0);
    chk("R3 held", rdata, 32'h5000_1111);
    // R1 reset mid-run
    cyc("R1", 1, 8'h20, 0, 1, 32'h0, 1, 4'h0);
    cyc("R1", 0, 8'h20, 1, 0, 0, 0, 0);
    chk("R1 again", rdata, 32'hA000_3020);
    // Random traffic near the map
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] a;
      a = 8'h1E + 8'($urandom_range(0, 10));
      cyc("R6", 0, a, 1'($urandom), 1'($urandom), $urandom,
          1'($urandom), 4'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule